// File: doc/BRIEF.md
# Snooping Write-Invalidate Line Coherence Controller

This block keeps the coherence state of one cache line belonging to one processor on a shared snooping bus. The line is Invalid, Shared or Exclusive (Exclusive meaning locally modified). Processor reads and writes are turned into bus transactions when the line lacks the needed permission. Transactions snooped from other caches may demote the line, and if the line is dirty they may force it to be written back.

A processor write to a Shared line only broadcasts an invalidate; it does not issue a full miss. A snooped read or write miss that finds the line Exclusive raises a write-back request and a memory-abort signal together, so that this cache supplies the block in place of memory. The tag comparison lives outside the block, and a single match input tells the controller whether a snooped address refers to the tracked line. Bus arbitration, the data arrays and multi-line storage are outside the block.

Encodings used on the ports: line state 0 = Invalid, 1 = Shared, 2 = Exclusive. Bus and snoop operation 0 = none, 1 = read miss, 2 = write miss, 3 = invalidate.

Top module: `snoop_line_ctrl`

## Requirements
- R1: While the synchronous active-high `rst` is high, at each clock edge the line becomes Invalid (0) and `busReqValid`, `wbReq` and `memAbort` become 0.
- R2: An accepted processor read to an Invalid line gives `busReqValid`=1 with `busReqOp`=1 (read miss) one edge later, and the line becomes Shared (1).
- R3: An accepted processor write to an Invalid line gives `busReqValid`=1 with `busReqOp`=2 (write miss) one edge later, and the line becomes Exclusive (2).
- R4: An accepted processor write to a Shared line gives `busReqValid`=1 with `busReqOp`=3 (invalidate) one edge later, and the line becomes Exclusive.
- R5: A processor read to a Shared or Exclusive line, or a write to an Exclusive line, issues no bus request and leaves the state unchanged.
- R6: A matching snooped invalidate (3) or write miss (2) moves a Shared line to Invalid with no write-back. A matching snooped read miss (1) leaves a Shared line Shared.
- R7: A matching snooped read miss to an Exclusive line pulses `wbReq` and `memAbort` one edge later, and the line becomes Shared.
- R8: A matching snooped write miss to an Exclusive line pulses `wbReq` and `memAbort` one edge later, and the line becomes Invalid.
- R9: A snoop with `snpMatch`=0, a snoop that finds the line Invalid, a snoop with op 0, or a snooped invalidate to an Exclusive line changes nothing and raises no output.
- R10: In any cycle where `snpValid` is 1, `cpuReady` is 0 and the processor request in that cycle is ignored; the snoop is acted on.
- R11: Every output pulse is registered and lasts one cycle: when no request or snoop is accepted in a cycle, `busReqValid`, `wbReq` and `memAbort` are 0 after the next edge and the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | 1 = processor write, 0 = processor read |
| cpuReady | output | 1 | Processor request accepted this cycle |
| snpValid | input | 1 | Snooped bus transaction present |
| snpOp | input | 2 | Snooped operation: 0 none, 1 read miss, 2 write miss, 3 invalidate |
| snpMatch | input | 1 | Snooped address matches the tracked line's tag |
| busReqValid | output | 1 | One-cycle request to place a transaction on the bus |
| busReqOp | output | 2 | Bus operation to place (same encoding as snpOp) |
| wbReq | output | 1 | One-cycle write-back request for the line |
| memAbort | output | 1 | One-cycle abort of the memory response to the snooped miss |
| lineState | output | 2 | Line state: 0 Invalid, 1 Shared, 2 Exclusive |

## Verification
Every combination of processor valid, read or write, snoop valid, all four snoop codes and the tag-match bit is applied from each of the three line states. The cases differ in what they show. Processor-only patterns separate the three miss and upgrade encodings from silent hits. Matching snoops separate the Shared demotions from the Exclusive write-backs. Non-matching snoops, code 0 and snoops to an Invalid line show that nothing happens. Patterns with both sources active show that the snoop wins and the processor request has no effect. After each pattern an idle cycle shows that the pulses drop and the state holds.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2
  } lineSt_e;

  typedef enum logic [1:0] {
    BUS_NONE   = 2'd0,
    BUS_RDMISS = 2'd1,
    BUS_WRMISS = 2'd2,
    BUS_INVAL  = 2'd3
  } busOp_e;

  // strobes from control to the state/output registers
  typedef struct packed {
    lineSt_e nextState;
    logic    issueBus;
    busOp_e  busOp;
    logic    flushLine;
  } cohStrobe_t;
endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  lineSt_e    curState,
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       snpValid,
  input  logic [1:0] snpOp,
  input  logic       snpMatch,
  output logic       cpuReady,
  output cohStrobe_t strobe
);
  busOp_e snoopKind;
  assign snoopKind = busOp_e'(snpOp);

  always_comb begin
    strobe.nextState = curState;
    strobe.issueBus  = 1'b0;
    strobe.busOp     = BUS_NONE;
    strobe.flushLine = 1'b0;
    cpuReady         = !snpValid;

    if (snpValid) begin
      // snoop side has priority; processor waits
      if (snpMatch) begin
        unique case (curState)
          LINE_SHR: begin
            if (snoopKind == BUS_WRMISS || snoopKind == BUS_INVAL)
              strobe.nextState = LINE_INV;
          end
          LINE_EXC: begin
            if (snoopKind == BUS_RDMISS) begin
              strobe.nextState = LINE_SHR;
              strobe.flushLine = 1'b1;
            end else if (snoopKind == BUS_WRMISS) begin
              strobe.nextState = LINE_INV;
              strobe.flushLine = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end else if (cpuValid) begin
      unique case (curState)
        LINE_INV: begin
          strobe.issueBus  = 1'b1;
          strobe.busOp     = cpuWrite ? BUS_WRMISS : BUS_RDMISS;
          strobe.nextState = cpuWrite ? LINE_EXC : LINE_SHR;
        end
        LINE_SHR: begin
          if (cpuWrite) begin
            strobe.issueBus  = 1'b1;
            strobe.busOp     = BUS_INVAL;
            strobe.nextState = LINE_EXC;
          end
        end
        default: ;
      endcase
    end
  end

  // R7 R8: a flush is only ever requested for a dirty line
  always_comb begin
    if (strobe.flushLine)
      flush_dirty_only_chk: assert (curState == LINE_EXC);
  end
endmodule

// File: rtl/coh_regs.sv
module coh_regs
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cohStrobe_t strobe,
  output lineSt_e    lineState,
  output logic       busReqValid,
  output busOp_e     busReqOp,
  output logic       wbReq,
  output logic       memAbort
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lineState   <= LINE_INV;
      busReqValid <= 1'b0;
      busReqOp    <= BUS_NONE;
      wbReq       <= 1'b0;
      memAbort    <= 1'b0;
    end else begin
      lineState   <= strobe.nextState;
      busReqValid <= strobe.issueBus;
      busReqOp    <= strobe.issueBus ? strobe.busOp : BUS_NONE;
      wbReq       <= strobe.flushLine;
      memAbort    <= strobe.flushLine;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (lineState == LINE_INV && !busReqValid && !wbReq));

  // R2
  rdmiss_chk: assert property (@(posedge clk) disable iff (rst)
    (busReqValid && busReqOp == BUS_RDMISS) |->
      ($past(lineState) == LINE_INV && lineState == LINE_SHR));

  // R3
  wrmiss_chk: assert property (@(posedge clk) disable iff (rst)
    (busReqValid && busReqOp == BUS_WRMISS) |->
      ($past(lineState) == LINE_INV && lineState == LINE_EXC));

  // R4
  upgrade_chk: assert property (@(posedge clk) disable iff (rst)
    (busReqValid && busReqOp == BUS_INVAL) |->
      ($past(lineState) == LINE_SHR && lineState == LINE_EXC));

  // R7 R8
  wb_from_excl_chk: assert property (@(posedge clk) disable iff (rst)
    wbReq |-> ($past(lineState) == LINE_EXC && lineState != LINE_EXC));

  // R11
  wb_single_chk: assert property (@(posedge clk) disable iff (rst)
    wbReq |=> !wbReq);

  // R11
  wb_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    wbReq |-> !busReqValid);
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuValid,
  input  logic       cpuWrite,
  output logic       cpuReady,
  input  logic       snpValid,
  input  logic [1:0] snpOp,
  input  logic       snpMatch,
  output logic       busReqValid,
  output logic [1:0] busReqOp,
  output logic       wbReq,
  output logic       memAbort,
  output logic [1:0] lineState
);
  cohStrobe_t strobe;
  lineSt_e    stateQ;
  busOp_e     opQ;

  coh_ctrl u_ctrl (
    .curState (stateQ),
    .cpuValid (cpuValid),
    .cpuWrite (cpuWrite),
    .snpValid (snpValid),
    .snpOp    (snpOp),
    .snpMatch (snpMatch),
    .cpuReady (cpuReady),
    .strobe   (strobe)
  );

  coh_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .lineState   (stateQ),
    .busReqValid (busReqValid),
    .busReqOp    (opQ),
    .wbReq       (wbReq),
    .memAbort    (memAbort)
  );

  assign lineState = stateQ;
  assign busReqOp  = opQ;

  // R10: a processor miss colliding with a snoop is dropped
  snoop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (snpValid && cpuValid && stateQ == LINE_INV) |=> !busReqValid);
endmodule

// File: tb/snoop_line_ctrl_bench.sv
`timescale 1ns/1ps
module snoop_line_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpuValid = 1'b0, cpuWrite = 1'b0;
  logic       snpValid = 1'b0, snpMatch = 1'b0;
  logic [1:0] snpOp = 2'd0;
  logic       cpuReady, busReqValid, wbReq, memAbort;
  logic [1:0] busReqOp, lineState;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  snoop_line_ctrl u_snoop_line_ctrl (
    .clk(clk), .rst(rst),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuReady(cpuReady),
    .snpValid(snpValid), .snpOp(snpOp), .snpMatch(snpMatch),
    .busReqValid(busReqValid), .busReqOp(busReqOp),
    .wbReq(wbReq), .memAbort(memAbort), .lineState(lineState)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idleIn();
    cpuValid = 1'b0; cpuWrite = 1'b0;
    snpValid = 1'b0; snpOp = 2'd0; snpMatch = 1'b0;
  endtask

  // bring the line to state st: 0 Invalid, 1 Shared, 2 Exclusive
  task automatic gotoState(input int st);
    idleIn();
    rst = 1'b1;
    step();
    rst = 1'b0;
    if (st != 0) begin
      cpuValid = 1'b1;
      cpuWrite = (st == 2);
      step();
      idleIn();
      step();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idleIn();
    rst = 1'b1;
    step();
    step();
    check("R1", "lineState", lineState, 0);
    check("R1", "busReqValid", busReqValid, 0);
    check("R1", "wbReq", wbReq, 0);
    check("R1", "memAbort", memAbort, 0);
    rst = 1'b0;

    for (int st = 0; st < 3; st++) begin
      for (int v = 0; v < 64; v++) begin
        int nst, bus, op, wb;
        string tag;
        logic cv, cw, sv, sm;
        logic [1:0] so;
        cv = v[0]; cw = v[1]; sv = v[2]; so = v[4:3]; sm = v[5];

        gotoState(st);
        check("R1", "start state", lineState, st);

        // expected result from the requirements
        nst = st; bus = 0; op = 0; wb = 0; tag = "R11";
        if (sv) begin
          tag = cv ? "R10" : "R9";
          if (sm && st == 1 && (so == 2 || so == 3)) begin nst = 0; tag = "R6"; end
          else if (sm && st == 1 && so == 1) tag = "R6";
          else if (sm && st == 2 && so == 1) begin nst = 1; wb = 1; tag = "R7"; end
          else if (sm && st == 2 && so == 2) begin nst = 0; wb = 1; tag = "R8"; end
        end else if (cv) begin
          if (st == 0) begin
            bus = 1; op = cw ? 2 : 1; nst = cw ? 2 : 1; tag = cw ? "R3" : "R2";
          end else if (st == 1 && cw) begin
            bus = 1; op = 3; nst = 2; tag = "R4";
          end else tag = "R5";
        end
        if (sv && cv && tag != "R10") tag = {tag, "/R10"};

        cpuValid = cv; cpuWrite = cw; snpValid = sv; snpOp = so; snpMatch = sm;
        #1;
        check("R10", "cpuReady", cpuReady, !sv);
        step();
        idleIn();
        check(tag, "lineState", lineState, nst);
        check(tag, "busReqValid", busReqValid, bus);
        if (bus != 0) check(tag, "busReqOp", busReqOp, op);
        check(tag, "wbReq", wbReq, wb);
        check(tag, "memAbort", memAbort, wb);

        step();
        check("R11", "busReqValid after idle", busReqValid, 0);
        check("R11", "wbReq after idle", wbReq, 0);
        check("R11", "memAbort after idle", memAbort, 0);
        check("R11", "state hold", lineState, nst);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule